// File: doc/BRIEF.md
# Strided Descriptor Transfer Engine

This engine moves blocks of words between physical memory and an accelerator's local buffer. A small descriptor table, loaded through its own write port, describes each region as a two-dimensional pattern. Each entry gives a physical base, a row stride, the number of words per row, the number of rows and a local base. It also carries a direction bit and a flag that ends a chain. When a command names a first descriptor, the engine walks that descriptor and the ones that follow it in index order. It issues one word access per memory handshake and signals completion with a single-cycle pulse.

The read direction fills the local buffer from memory, which is how a block is staged before the accelerator runs. The write direction drains the local buffer back to memory once the accelerator has finished, so the command is issued only after processing ends. The local pointer starts at the local base of the first descriptor in the chain. It runs linearly through every word of the command, so chained regions land back to back in the local buffer.

Top module: `strided_xfer_engine`

## Requirements
- R1: After reset, mem_req, mem_we, lb_we, cmd_done and busy are all 0.
- R2: Words are visited row by row and, within a row, column by column. The physical address is base + row*stride + column, taken modulo 2^PAW.
- R3: While mem_req is high and mem_ack is low, mem_req stays high and mem_addr and mem_we hold. The engine advances exactly one word per cycle in which mem_req and mem_ack are both high.
- R4: When the direction bit is 0 (memory to buffer), the accepted cycle has lb_we=1, lb_waddr equal to the local pointer and lb_wdata equal to mem_rdata. In this direction mem_we is 0.
- R5: When the direction bit is 1 (buffer to memory), mem_we is 1, lb_raddr equals the local pointer, mem_wdata equals lb_rdata, and lb_we stays 0.
- R6: The local pointer begins at the local base of the command's first descriptor. It rises by one per accepted word across all chained descriptors, modulo 2^LAW. The local bases of later descriptors are not used.
- R7: After a descriptor, the engine continues with index+1, wrapping from NDESC-1 to 0, unless that descriptor's last flag is 1.
- R8: A descriptor with zero words per row or zero rows causes no memory request and costs one cycle.
- R9: cmd_done is high for exactly one cycle. When the last non-empty descriptor ends the chain, that cycle is the one after the cycle in which its final word was accepted. Each skipped descriptor that follows it adds one cycle. busy is 0 in the cycle after cmd_done.
- R10: cmd_start is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsc_wr | input | 1 | Write one descriptor entry |
| dsc_sel | input | $clog2(NDESC) | Entry index to write |
| dsc_phys | input | PAW | Physical base address |
| dsc_loc | input | LAW | Local base address |
| dsc_cols | input | CW | Words per row |
| dsc_rows | input | CW | Number of rows |
| dsc_stride | input | PAW | Row stride in words |
| dsc_to_mem | input | 1 | Direction: 1 = buffer to memory |
| dsc_last | input | 1 | Ends the chain |
| cmd_start | input | 1 | Start a command |
| cmd_sel | input | $clog2(NDESC) | First descriptor of the command |
| cmd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PAW | Physical word address |
| mem_wdata | output | DW | Write data to memory |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| lb_we | output | 1 | Local buffer write enable |
| lb_waddr | output | LAW | Local buffer write address |
| lb_wdata | output | DW | Local buffer write data |
| lb_raddr | output | LAW | Local buffer read address |
| lb_rdata | input | DW | Local buffer read data, combinational |

## Verification
Address, direction, local pointer and write data are all combinational from engine state. They are due in the same cycle that mem_req is high, and the bench compares them in that cycle against the head of a queue of expected words. The buffer write is due in the cycle where mem_ack is sampled high. The bench drives mem_ack one time unit after the rising edge and samples at the falling edge, so both sides see the same cycle. The done pulse is due one cycle after the final accepted word, plus one cycle per trailing skipped descriptor. For a chain with no words, it is due one cycle after the start is sampled, plus one cycle per descriptor. The bench precomputes that cycle number and flags a pulse that is early, late or missing.

// File: rtl/strided_xfer_engine.sv
module strided_xfer_engine #(
  parameter int NDESC = 8,
  parameter int PAW   = 16,
  parameter int LAW   = 10,
  parameter int CW    = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dsc_wr,
  input  logic [$clog2(NDESC)-1:0] dsc_sel,
  input  logic [PAW-1:0]           dsc_phys,
  input  logic [LAW-1:0]           dsc_loc,
  input  logic [CW-1:0]            dsc_cols,
  input  logic [CW-1:0]            dsc_rows,
  input  logic [PAW-1:0]           dsc_stride,
  input  logic                     dsc_to_mem,
  input  logic                     dsc_last,
  input  logic                     cmd_start,
  input  logic [$clog2(NDESC)-1:0] cmd_sel,
  output logic                     cmd_done,
  output logic                     busy,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [PAW-1:0]           mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic                     mem_ack,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     lb_we,
  output logic [LAW-1:0]           lb_waddr,
  output logic [DW-1:0]            lb_wdata,
  output logic [LAW-1:0]           lb_raddr,
  input  logic [DW-1:0]            lb_rdata
);
  localparam int IW = $clog2(NDESC);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_MOVE, S_FIN} st_t;

  logic [PAW-1:0] t_phys   [NDESC];
  logic [LAW-1:0] t_loc    [NDESC];
  logic [CW-1:0]  t_cols   [NDESC];
  logic [CW-1:0]  t_rows   [NDESC];
  logic [PAW-1:0] t_stride [NDESC];
  logic           t_dir    [NDESC];
  logic           t_last   [NDESC];

  st_t            st;
  logic [IW-1:0]  idx;
  logic [LAW-1:0] lptr;
  logic [CW-1:0]  row, col, n_cols, n_rows;
  logic [PAW-1:0] rbase, stride;
  logic           dir, last;

  logic           empty, acc, eol, eor;
  logic [IW-1:0]  idx_nx;

  assign empty  = (t_cols[idx] == '0) || (t_rows[idx] == '0);
  assign idx_nx = (idx == IW'(NDESC - 1)) ? '0 : idx + 1'b1;
  assign acc    = mem_req & mem_ack;
  assign eol    = col == n_cols - CW'(1);
  assign eor    = row == n_rows - CW'(1);

  assign busy      = st != S_IDLE;
  assign cmd_done  = st == S_FIN;
  assign mem_req   = st == S_MOVE;
  assign mem_we    = mem_req & dir;
  assign mem_addr  = rbase + PAW'(col);
  assign mem_wdata = lb_rdata;
  assign lb_raddr  = lptr;
  assign lb_waddr  = lptr;
  assign lb_wdata  = mem_rdata;
  assign lb_we     = acc & ~dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        t_phys[i]   <= '0;
        t_loc[i]    <= '0;
        t_cols[i]   <= '0;
        t_rows[i]   <= '0;
        t_stride[i] <= '0;
        t_dir[i]    <= 1'b0;
        t_last[i]   <= 1'b1;
      end
    end else if (dsc_wr) begin
      t_phys[dsc_sel]   <= dsc_phys;
      t_loc[dsc_sel]    <= dsc_loc;
      t_cols[dsc_sel]   <= dsc_cols;
      t_rows[dsc_sel]   <= dsc_rows;
      t_stride[dsc_sel] <= dsc_stride;
      t_dir[dsc_sel]    <= dsc_to_mem;
      t_last[dsc_sel]   <= dsc_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      lptr   <= '0;
      row    <= '0;
      col    <= '0;
      n_cols <= '0;
      n_rows <= '0;
      rbase  <= '0;
      stride <= '0;
      dir    <= 1'b0;
      last   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_start) begin
          idx  <= cmd_sel;
          lptr <= t_loc[cmd_sel];
          st   <= S_LOAD;
        end
        S_LOAD: begin
          if (empty) begin
            if (t_last[idx]) st <= S_FIN;
            else idx <= idx_nx;
          end else begin
            row    <= '0;
            col    <= '0;
            rbase  <= t_phys[idx];
            stride <= t_stride[idx];
            n_cols <= t_cols[idx];
            n_rows <= t_rows[idx];
            dir    <= t_dir[idx];
            last   <= t_last[idx];
            st     <= S_MOVE;
          end
        end
        S_MOVE: if (acc) begin
          lptr <= lptr + 1'b1;
          if (!eol) col <= col + 1'b1;
          else begin
            col <= '0;
            if (!eor) begin
              row   <= row + 1'b1;
              rbase <= rbase + stride;
            end else if (last) st <= S_FIN;
            else begin
              idx <= idx_nx;
              st  <= S_LOAD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strided_xfer_engine_chk.sv
module strided_xfer_engine_chk #(
  parameter int PAW = 16,
  parameter int LAW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [PAW-1:0] mem_addr,
  input logic           lb_we,
  input logic [LAW-1:0] lb_raddr,
  input logic           cmd_done,
  input logic           busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

  AST_LB_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> (mem_req && mem_ack && !mem_we)); // R4

  AST_WB_NO_LB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !lb_we); // R5

  AST_LOCAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || lb_raddr == LAW'($past(lb_raddr) + 1'b1))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (!cmd_done && !busy)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !cmd_done)); // R1
endmodule

bind strided_xfer_engine strided_xfer_engine_chk #(.PAW(PAW), .LAW(LAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .lb_we(lb_we), .lb_raddr(lb_raddr), .cmd_done(cmd_done), .busy(busy)
);

// File: tb/strided_xfer_engine_tb_top.sv
module strided_xfer_engine_tb_top;
  localparam int NDESC = 8, PAW = 16, LAW = 10, CW = 8, DW = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic dsc_wr = 0, dsc_to_mem = 0, dsc_last = 0, cmd_start = 0, mem_ack = 0;
  logic [2:0] dsc_sel = 0, cmd_sel = 0;
  logic [PAW-1:0] dsc_phys = 0, dsc_stride = 0;
  logic [LAW-1:0] dsc_loc = 0;
  logic [CW-1:0] dsc_cols = 0, dsc_rows = 0;
  logic cmd_done, busy, mem_req, mem_we, lb_we;
  logic [PAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, lb_wdata, lb_rdata;
  logic [LAW-1:0] lb_waddr, lb_raddr;

  logic [DW-1:0] lbuf [1024];
  assign mem_rdata = {16'hA5A5, mem_addr};
  assign lb_rdata  = lbuf[lb_raddr];

  strided_xfer_engine dut_i (.*);

  int checks = 0, failures = 0, cyc = 0, due_done = -1;
  bit stall = 0, pend_done = 0;
  int q_addr[$], q_we[$], q_la[$];
  int trail = 0;
  int b_phys[NDESC], b_loc[NDESC], b_cols[NDESC], b_rows[NDESC], b_str[NDESC], b_dir[NDESC], b_last[NDESC];

  initial for (int i = 0; i < 1024; i++) lbuf[i] = 32'h1000 + i * 3;
  always @(posedge clk) if (lb_we) lbuf[lb_waddr] <= lb_wdata;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1 mem_ack <= mem_req && (!stall || (cyc % 3 != 1));
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_req) begin
      if (q_addr.size() == 0) chk(0, "R8/R10 unexpected request", mem_addr, -1);
      else begin
        chk(mem_addr == q_addr[0][15:0], "R2 address", mem_addr, q_addr[0]);
        chk(mem_we == q_we[0][0], "R4/R5 direction", mem_we, q_we[0]);
        chk(lb_raddr == q_la[0][9:0], "R6 local pointer", lb_raddr, q_la[0]);
        if (mem_we) begin
          chk(mem_wdata == lbuf[q_la[0]], "R5 write data", mem_wdata, lbuf[q_la[0]]);
          chk(!lb_we, "R5 no buffer write", lb_we, 0);
        end
        if (mem_ack) begin
          if (!mem_we) begin
            chk(lb_we && lb_waddr == q_la[0][9:0], "R4 buffer write addr", lb_waddr, q_la[0]);
            chk(lb_wdata == {16'hA5A5, q_addr[0][15:0]}, "R4 buffer write data", lb_wdata, q_addr[0]);
          end
          void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_la.pop_front());
          if (q_addr.size() == 0) due_done = cyc + 1 + trail;
        end else chk(!lb_we, "R3 no write while stalled", lb_we, 0);
      end
    end else chk(!lb_we, "R3 buffer write without request", lb_we, 0);
    if (cmd_done || cyc == due_done) begin
      chk(cmd_done && cyc == due_done, "R9 done timing", cyc, due_done);
      if (cmd_done) due_done = -1;
    end
  end

  task automatic prog(int i, int ph, int lo, int co, int ro, int st, int dr, int la);
    @(posedge clk); #1;
    dsc_wr = 1; dsc_sel = 3'(i); dsc_phys = PAW'(ph); dsc_loc = LAW'(lo);
    dsc_cols = CW'(co); dsc_rows = CW'(ro); dsc_stride = PAW'(st);
    dsc_to_mem = dr[0]; dsc_last = la[0];
    b_phys[i] = ph; b_loc[i] = lo; b_cols[i] = co; b_rows[i] = ro; b_str[i] = st; b_dir[i] = dr; b_last[i] = la;
    @(posedge clk); #1 dsc_wr = 0;
  endtask

  task automatic run(int first, bit intr, int intr_sel);
    int i = first, la = b_loc[first], nload = 0, p;
    bit got = 0;
    trail = 0;
    forever begin
      nload++;
      if (b_cols[i] != 0 && b_rows[i] != 0) begin
        trail = 0;
        for (int r = 0; r < b_rows[i]; r++)
          for (int c = 0; c < b_cols[i]; c++) begin
            q_addr.push_back((b_phys[i] + r * b_str[i] + c) & 16'hFFFF);
            q_we.push_back(b_dir[i]);
            q_la.push_back(la & 10'h3FF);
            la++;
          end
      end else trail++;
      if (b_last[i] != 0) break;
      i = (i + 1) % NDESC;
    end
    @(posedge clk); #1;
    cmd_start = 1; cmd_sel = 3'(first); p = cyc;
    if (q_addr.size() == 0) due_done = p + 1 + nload;
    @(posedge clk); #1 cmd_start = 0;
    if (intr) begin
      repeat (2) @(posedge clk);
      #1 cmd_start = 1; cmd_sel = 3'(intr_sel);
      @(posedge clk); #1 cmd_start = 0;
    end
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      got = cmd_done;
    end
    chk(got, "R9 done seen", got, 1);
    chk(q_addr.size() == 0, "R7 all chained words visited", q_addr.size(), 0);
    @(negedge clk);
    chk(!busy && !cmd_done, "R9/R10 idle after done", busy, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R10 no second command", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !mem_we && !lb_we && !cmd_done && !busy, "R1 reset state",
        {mem_req, mem_we, lb_we, cmd_done, busy}, 0);
    // R2 R4 R6: 2D read into buffer
    prog(0, 'h0100, 5, 3, 2, 16, 0, 1);
    run(0, 0, 0);
    // R5: write-back, with stalls (R3)
    stall = 1;
    prog(1, 'h0200, 5, 2, 3, 'h40, 1, 1);
    run(1, 0, 0);
    // R7 R8: chain with skipped entries, address wrap, trailing skip
    prog(2, 'h0300, 20, 4, 1, 0, 0, 0);
    prog(3, 'h0000, 0, 0, 5, 1, 0, 0);
    prog(4, 'hFFF0, 99, 2, 3, 8, 1, 0);
    prog(5, 'h0000, 0, 3, 0, 1, 0, 1);
    run(2, 0, 0);
    stall = 0;
    // R8: chain with no words at all
    prog(6, 'h0400, 0, 0, 2, 1, 0, 0);
    prog(7, 'h0500, 0, 2, 0, 1, 0, 1);
    run(6, 0, 0);
    // R7: index wraps from 7 to 0
    prog(7, 'h0600, 40, 2, 1, 0, 0, 0);
    run(7, 0, 0);
    // R10: start during a busy command is ignored
    stall = 1;
    run(0, 1, 4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule